// File: doc/BRIEF.md
# Masked Interrupt Request Aggregator

This block collects the interrupt-request lines of up to 24 stations on a crate backplane and reduces them to one host interrupt. Each line is active low: a station asserts its request by pulling the line low. The lines are first brought into the block clock domain, and then an assertion edge (high-to-low) is detected on each line. An assertion edge on a station whose bit is set in a programmable mask sets one sticky request flag. That flag stays set until the host pulses a clear strobe, and the host interrupt is the flag gated by an interrupt-enable input.

Software reads a set of status words through a small register port made of a select code, a write enable and 32-bit data. The readable words are the mask itself, the raw pending requests, the pending requests from enabled stations, and the pending requests from disabled stations. Each of these words also carries four summary bits at the top. A separate word returns the flag alone.

Top module: `irq_aggregator`

## Requirements
- R1: After `rst_ni` is asserted, the mask is all zero, the flag is clear and `irq_o` is 0. An assertion of `rst_ni` in the middle of operation clears both the mask and the flag.
- R2: A write with `sel_i`=0 loads the mask from `wdata_i[23:0]`, where bit 0 is station 1 and bit 23 is station 24. Bits 31:24 of the write data are ignored. A read with `sel_i`=0 returns the mask in bits 23:0. Writes with any other select code leave the mask unchanged.
- R3: The flag is set only by a high-to-low transition of a request line whose mask bit is 1. A line that is already low when its mask bit becomes 1 does not set the flag.
- R4: A high-to-low transition on a station whose mask bit is 0 does not set the flag.
- R5: Once set, the flag stays set through later edges and releases of request lines. It clears only on a cycle with `ff_clr_i`=1.
- R6: If a qualifying edge and `ff_clr_i` occur in the same cycle, the flag ends up set.
- R7: Bits 23:0 of the read data depend on the select code. For `sel_i`=2 they are the pending requests (line low = 1). For `sel_i`=3 they are the pending requests AND the mask. For `sel_i`=4 they are the pending requests AND NOT the mask.
- R8: For select codes 0, 2, 3 and 4, the top bits of the read data are summary bits. Bit 28 is the OR of all pending requests. Bit 29 is the OR of pending requests from disabled stations. Bit 30 is the OR of pending requests from enabled stations. Bit 31 is the flag.
- R9: A read with `sel_i`=1 returns the flag in bit 0, with all other bits 0.
- R10: `irq_o` is 1 exactly when the flag is set and `irq_en_i` is 1.
- R11: A request line passes through two synchronising stages. A change on a line appears in the status words after two clock edges, and a qualifying edge sets the flag on the third clock edge.
- R12: Read data bits 27:24 are always 0, and select codes 5 to 7 read as all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low global reset |
| req_ni | input | 24 | Station request lines, active low, asynchronous |
| sel_i | input | 3 | Register select code |
| wr_en_i | input | 1 | Write strobe for the selected register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the selected register (combinational) |
| ff_clr_i | input | 1 | Clear strobe for the sticky flag |
| irq_en_i | input | 1 | Host interrupt enable |
| irq_o | output | 1 | Host interrupt |

## Verification
The bench builds the block with its defaults: 24 stations, a 32-bit word and two synchroniser stages. With these values the full station range is in reach, from station 1 at bit 0 to station 24 at bit 23. The summary bits also sit at their fixed positions above the padding. Two stages make the synchroniser latency short enough to check to the exact clock edge. This includes the edge on which a coincident clear strobe must lose to a new request.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  typedef enum logic [2:0] {
    SEL_MASK = 3'd0,
    SEL_FLAG = 3'd1,
    SEL_RAW  = 3'd2,
    SEL_EN   = 3'd3,
    SEL_DIS  = 3'd4
  } sel_e;

  localparam int SUM_ANY = 28;
  localparam int SUM_DIS = 29;
  localparam int SUM_EN  = 30;
  localparam int SUM_FF  = 31;
endpackage

// File: rtl/irqagg_sync.sv
module irqagg_sync #(
  parameter int W      = 24,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  // reset to idle-high so no false edge follows reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '1;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/irqagg_edge.sv
module irqagg_edge #(
  parameter int W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] line_i,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;
    else         prev_q <= line_i;
  end

  assign pend_o = ~line_i;
  assign fall_o = prev_q & ~line_i;
endmodule

// File: rtl/irqagg_flag.sv
module irqagg_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  // set wins over clear so a coincident event is kept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/irqagg_status.sv
module irqagg_status
  import irqagg_pkg::*;
#(
  parameter int N_STN = 24,
  parameter int DW    = 32
) (
  input  logic [2:0]       sel_i,
  input  logic [N_STN-1:0] pend_i,
  input  logic [N_STN-1:0] mask_i,
  input  logic             flag_i,
  output logic [DW-1:0]    rdata_o
);
  localparam int PAD = SUM_ANY - N_STN;

  logic [N_STN-1:0] en_v, dis_v, body;
  logic [3:0]       sum;
  logic             sum_sel;

  assign en_v  = pend_i & mask_i;
  assign dis_v = pend_i & ~mask_i;
  assign sum   = {flag_i, |en_v, |dis_v, |pend_i};

  always_comb begin
    body    = '0;
    sum_sel = 1'b1;
    unique case (sel_e'(sel_i))
      SEL_MASK: body = mask_i;
      SEL_RAW:  body = pend_i;
      SEL_EN:   body = en_v;
      SEL_DIS:  body = dis_v;
      default:  sum_sel = 1'b0;
    endcase
  end

  always_comb begin
    if (sel_e'(sel_i) == SEL_FLAG)
      rdata_o = {{(DW-1){1'b0}}, flag_i};
    else if (sum_sel)
      rdata_o = {sum, {PAD{1'b0}}, body};
    else
      rdata_o = '0;
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irqagg_pkg::*;
#(
  parameter int N_STN  = 24,
  parameter int DW     = 32,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_STN-1:0] req_ni,
  input  logic [2:0]       sel_i,
  input  logic             wr_en_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic             ff_clr_i,
  input  logic             irq_en_i,
  output logic             irq_o
);
  logic [N_STN-1:0] line_s, pend, fall, mask_q;
  logic             flag, set_ev;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i[DW-1:N_STN];

  irqagg_sync #(.W(N_STN), .STAGES(STAGES)) i_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(req_ni), .q_o(line_s)
  );

  irqagg_edge #(.W(N_STN)) i_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_i(line_s),
    .pend_o(pend), .fall_o(fall)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      mask_q <= '0;
    else if (wr_en_i && sel_e'(sel_i) == SEL_MASK)
      mask_q <= wdata_i[N_STN-1:0];
  end

  assign set_ev = |(fall & mask_q);

  irqagg_flag i_flag (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set_ev), .clr_i(ff_clr_i),
    .flag_o(flag)
  );

  irqagg_status #(.N_STN(N_STN), .DW(DW)) i_status (
    .sel_i(sel_i), .pend_i(pend), .mask_i(mask_q), .flag_i(flag),
    .rdata_o(rdata_o)
  );

  assign irq_o = flag & irq_en_i;
endmodule

// File: rtl/irqagg_chk.sv
module irqagg_chk #(
  parameter int N_STN = 24,
  parameter int DW    = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       sel_i,
  input logic             wr_en_i,
  input logic             ff_clr_i,
  input logic             irq_en_i,
  input logic             irq_o,
  input logic [DW-1:0]    rdata_o,
  input logic             flag,
  input logic [N_STN-1:0] mask_q,
  input logic [N_STN-1:0] fall
);
  p_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag && !ff_clr_i |=> flag);

  p_set_needs_edge_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag) |-> $past(|(fall & mask_q)));

  p_coincident_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(fall & mask_q)) && ff_clr_i |=> flag);

  p_irq_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> irq_en_i && rdata_o != '0 || sel_i != 3'd1);

  p_mask_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && sel_i == 3'd0) |=> $stable(mask_q));

  p_flag_word_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i == 3'd1 |-> rdata_o[DW-1:1] == '0);

  p_pad_zero_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[27:24] == 4'd0);

  p_summary_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i != 3'd1 && (rdata_o[30] || rdata_o[29]) |-> rdata_o[28]);
endmodule

bind irq_aggregator irqagg_chk #(.N_STN(N_STN), .DW(DW)) i_irqagg_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .wr_en_i(wr_en_i),
  .ff_clr_i(ff_clr_i), .irq_en_i(irq_en_i), .irq_o(irq_o),
  .rdata_o(rdata_o), .flag(flag), .mask_q(mask_q), .fall(fall)
);

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;
  localparam int N = 24;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  req_ni = '1;
  logic [2:0]    sel_i = 3'd0;
  logic          wr_en_i = 1'b0;
  logic [31:0]   wdata_i = '0;
  logic [31:0]   rdata_o;
  logic          ff_clr_i = 1'b0;
  logic          irq_en_i = 1'b0;
  logic          irq_o;

  int n_chk = 0;
  int n_err = 0;
  logic [N-1:0] m_mask = '0;
  logic         m_flag = 1'b0;

  always #4 clk_i = ~clk_i;

  irq_aggregator i_irq_aggregator (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_ni(req_ni), .sel_i(sel_i),
    .wr_en_i(wr_en_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .ff_clr_i(ff_clr_i), .irq_en_i(irq_en_i), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  function automatic logic [31:0] exp_word(input logic [2:0] s);
    logic [N-1:0] p, body;
    p = ~req_ni;
    case (s)
      3'd0: body = m_mask;
      3'd1: return {31'd0, m_flag};
      3'd2: body = p;
      3'd3: body = p & m_mask;
      3'd4: body = p & ~m_mask;
      default: return 32'd0;
    endcase
    return {m_flag, |(p & m_mask), |(p & ~m_mask), |p, 4'd0, body};
  endfunction

  task automatic rd(input string tag, input logic [2:0] s);
    sel_i = s;
    #1;
    chk(tag, rdata_o, exp_word(s));
  endtask

  task automatic wr_mask(input logic [31:0] v);
    sel_i = 3'd0; wdata_i = v; wr_en_i = 1'b1;
    tick(1);
    wr_en_i = 1'b0;
    m_mask = v[N-1:0];
  endtask

  task automatic pulse_clr();
    ff_clr_i = 1'b1;
    tick(1);
    ff_clr_i = 1'b0;
    m_flag = 1'b0;
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    tick(2);
    rst_ni = 1'b1;
    tick(1);
    chk("R1 irq after reset", {31'd0, irq_o}, 32'd0);
    rd("R1 mask after reset", 3'd0);
    rd("R1 flag after reset", 3'd1);
  endtask

  task automatic t_mask_rw();
    wr_mask(32'hFFA5_0001);
    rd("R2 mask readback", 3'd0);
    chk("R2 mask upper ignored", rdata_o, 32'h00A5_0001);
    sel_i = 3'd2; wdata_i = 32'h0000_FFFF; wr_en_i = 1'b1;
    tick(1);
    wr_en_i = 1'b0;
    rd("R2 other select no write", 3'd0);
  endtask

  task automatic t_enabled_edge();
    req_ni[0] = 1'b0;
    tick(1);
    sel_i = 3'd2; #1;
    chk("R11 raw after one edge", rdata_o, 32'd0);
    tick(1);
    rd("R11 raw after two edges", 3'd2);
    sel_i = 3'd1; #1;
    chk("R11 flag not yet set", rdata_o, 32'd0);
    tick(1);
    m_flag = 1'b1;
    rd("R3 flag set by enabled edge", 3'd1);
    req_ni[0] = 1'b1;
    tick(3);
    pulse_clr();
    rd("R5 flag cleared by strobe", 3'd1);
  endtask

  task automatic t_disabled_edge();
    req_ni[1] = 1'b0;
    tick(3);
    rd("R4 flag unaffected by disabled edge", 3'd1);
    rd("R7 disabled view", 3'd4);
    rd("R8 summaries disabled only", 3'd2);
    wr_mask(32'h00A5_0003);
    tick(2);
    rd("R3 held-low line after enable no set", 3'd1);
    rd("R7 enabled view after mask change", 3'd3);
    req_ni[1] = 1'b1;
    tick(3);
    rd("R3 release no set", 3'd1);
  endtask

  task automatic t_sticky();
    req_ni[0] = 1'b0;
    tick(3);
    m_flag = 1'b1;
    req_ni[0] = 1'b1;
    tick(3);
    rd("R5 flag holds after release", 3'd1);
    req_ni[16] = 1'b0;
    tick(3);
    req_ni[16] = 1'b1;
    tick(3);
    rd("R5 flag holds after second edge", 3'd1);
    pulse_clr();
    tick(2);
    rd("R5 flag stays clear", 3'd1);
  endtask

  task automatic t_coincident();
    req_ni[0] = 1'b0;
    tick(3);
    m_flag = 1'b1;
    req_ni[0] = 1'b1;
    tick(3);
    req_ni[18] = 1'b0;
    tick(2);
    ff_clr_i = 1'b1;
    tick(1);
    ff_clr_i = 1'b0;
    rd("R6 edge beats clear", 3'd1);
    pulse_clr();
    rd("R6 clear alone works", 3'd1);
    req_ni[18] = 1'b1;
    tick(3);
  endtask

  task automatic t_views();
    req_ni[0] = 1'b0; req_ni[1] = 1'b0; req_ni[5] = 1'b0; req_ni[23] = 1'b0;
    tick(3);
    m_flag = 1'b1;
    rd("R7 raw view", 3'd2);
    rd("R7 enabled view", 3'd3);
    rd("R7 disabled view", 3'd4);
    rd("R8 mask word with summaries", 3'd0);
    chk("R8 summary nibble", {28'd0, rdata_o[31:28]}, 32'hF);
    chk("R12 pad bits zero", {28'd0, rdata_o[27:24]}, 32'd0);
    rd("R12 unused select 5", 3'd5);
    rd("R12 unused select 7", 3'd7);
    rd("R9 flag word", 3'd1);
  endtask

  task automatic t_irq();
    irq_en_i = 1'b0; #1;
    chk("R10 irq gated off", {31'd0, irq_o}, 32'd0);
    irq_en_i = 1'b1; #1;
    chk("R10 irq on", {31'd0, irq_o}, 32'd1);
    pulse_clr();
    chk("R10 irq off after clear", {31'd0, irq_o}, 32'd0);
  endtask

  task automatic t_midreset();
    req_ni = '1;
    tick(3);
    req_ni[0] = 1'b0;
    tick(3);
    req_ni[0] = 1'b1;
    rst_ni = 1'b0;
    #1;
    m_mask = '0; m_flag = 1'b0;
    chk("R1 irq during reset", {31'd0, irq_o}, 32'd0);
    tick(1);
    rst_ni = 1'b1;
    tick(3);
    rd("R1 mask cleared by reset", 3'd0);
    rd("R1 flag cleared by reset", 3'd1);
  endtask

  initial begin
    @(negedge clk_i);
    t_reset();
    t_mask_rw();
    t_enabled_edge();
    t_disabled_edge();
    t_sticky();
    t_coincident();
    t_views();
    t_irq();
    t_midreset();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #100000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule